// File: doc/BRIEF.md
# Front-Panel Memory Examine Controller

This block lets an operator read memory from a front panel. Two push switches, Examine and Examine Next, together with a bank of address switches, are turned into the control strobes a small memory system needs. Examine copies the address switches into a held address register. Examine Next advances that register by one. Each accepted action then places the held address on a shared address bus, asserts a memory read, and strobes a display latch so the operator sees the address and the data that was read.

Both switch inputs pass through a two-flop synchroniser and a rising-edge detector, so one press gives one action. A sequencer steps through four named states. ST_IDLE waits for a press. ST_LOAD (taken on an Examine press) or ST_STEP (taken on an Examine Next press) lasts one cycle and pulses the register control. ST_READ follows and drives the bus and the read strobe. ST_SHOW keeps the bus and the read strobe and also pulses the display latch, then the sequencer returns to ST_IDLE. The transitions are: ST_IDLE to ST_LOAD or ST_STEP on a valid press, ST_LOAD and ST_STEP to ST_READ, ST_READ to ST_SHOW, ST_SHOW to ST_IDLE. From any state the sequencer goes to ST_IDLE while the processor holds the bus.

The address bus driver is high-impedance unless the panel owns the bus. A single request input from the processor side takes the bus away from the panel at once and blocks new panel actions.

Top module: `panel_examine_ctrl`

## Requirements
- R1: After reset the held address is zero and the controller sits idle with `addr_load` low, `addr_step` low, `bus_oe_n` high, `mem_rd` low and `disp_latch` low.
- R2: A rising edge on `sw_examine` (with `sw_exam_next` low), arriving while idle, gives exactly one cycle of `addr_load` three clock edges after the switch is first sampled high, and the held address takes the value of `sw_addr` in that cycle.
- R3: A rising edge on `sw_exam_next` (with `sw_examine` low), arriving while idle, gives exactly one cycle of `addr_step`, and the held address grows by exactly one.
- R4: Stepping from an all-ones address gives address zero.
- R5: In the two cycles after an `addr_load` or `addr_step` pulse, `bus_oe_n` is low and `bus_addr` equals the held address; at all other times `bus_oe_n` is high and the bus is high-impedance.
- R6: `mem_rd` is high exactly when `bus_oe_n` is low, and `disp_latch` is high only in the second of those two cycles.
- R7: A press on one switch while the other switch is already held (including both rising together) is invalid: no pulse, no bus drive, no change of the held address.
- R8: While `cpu_owns_bus` is high, `bus_oe_n` is high, `mem_rd`, `disp_latch`, `addr_load` and `addr_step` are low, a running sequence is abandoned, and presses seen in that time are lost.
- R9: Holding a switch down gives one action only, and a press whose edge arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_examine | input | 1 | Examine switch, asynchronous, high when pressed |
| sw_exam_next | input | 1 | Examine Next switch, asynchronous, high when pressed |
| sw_addr | input | 16 | Address switches, assumed steady around a press |
| cpu_owns_bus | input | 1 | High while the processor owns the address bus |
| bus_addr | output | 16 | Shared address bus, high-impedance when not driven |
| bus_oe_n | output | 1 | Active-low bus drive enable |
| mem_rd | output | 1 | Memory read strobe |
| disp_latch | output | 1 | Display latch strobe |
| addr_load | output | 1 | One-cycle pulse: held address loaded from switches |
| addr_step | output | 1 | One-cycle pulse: held address advanced by one |

## Verification
The bench steers into the cases where a control decoder most often goes wrong: a switch held for many cycles, which a level-sensitive design would turn into a stream of loads or a runaway counter; a second press landing inside a running sequence, which a careless design would restart; the two switches overlapping, which a priority decoder would wrongly resolve to one action; and a step from all ones, where a wrong width or a saturating counter would not give zero. It also raises the processor request in the middle of a sequence, where a design that only checked the request in the idle state would keep driving the bus against the processor, and it shows that presses made under the request leave the held address unchanged.

// File: rtl/pnl_pkg.sv
package pnl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_STEP = 3'd2,
        ST_READ = 3'd3,
        ST_SHOW = 3'd4
    } pnl_state_e;

    localparam int SW_COUNT = 2;
    localparam int SW_EXAM  = 0;
    localparam int SW_NEXT  = 1;

endpackage

// File: rtl/pnl_sw_sync.sv
module pnl_sw_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] level,
    output logic [N-1:0] rise
);

    localparam int DEPTH = STAGES + 1;

    logic [N-1:0] pipe [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe[0] <= '0;
        end else begin
            pipe[0] <= raw;
        end
    end

    generate
        for (genvar s = 1; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[s] <= '0;
                end else begin
                    pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    // Level after the synchroniser; the extra flop gives the edge history.
    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/pnl_seq_fsm.sv
module pnl_seq_fsm
    import pnl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exam_rise,
    input  logic next_rise,
    input  logic exam_level,
    input  logic next_level,
    input  logic cpu_owns_bus,
    output logic ld_pulse,
    output logic step_pulse,
    output logic oe_n,
    output logic rd,
    output logic latch
);

    pnl_state_e state_q;
    pnl_state_e state_d;

    logic exam_go;
    logic next_go;

    // A press counts only when the other switch is released.
    assign exam_go = exam_rise & ~next_level;
    assign next_go = next_rise & ~exam_level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (cpu_owns_bus) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (exam_go) begin
                        state_d = ST_LOAD;
                    end else if (next_go) begin
                        state_d = ST_STEP;
                    end
                end
                ST_LOAD: state_d = ST_READ;
                ST_STEP: state_d = ST_READ;
                ST_READ: state_d = ST_SHOW;
                ST_SHOW: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ld_pulse   = 1'b0;
        step_pulse = 1'b0;
        oe_n       = 1'b1;
        rd         = 1'b0;
        latch      = 1'b0;
        if (!cpu_owns_bus) begin
            unique case (state_q)
                ST_IDLE: ;
                ST_LOAD: ld_pulse = 1'b1;
                ST_STEP: step_pulse = 1'b1;
                ST_READ: begin
                    oe_n = 1'b0;
                    rd   = 1'b1;
                end
                ST_SHOW: begin
                    oe_n  = 1'b0;
                    rd    = 1'b1;
                    latch = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pnl_addr_hold.sv
module pnl_addr_hold #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          step,
    input  logic          oe_n,
    input  logic [AW-1:0] sw_addr,
    output logic [AW-1:0] held,
    output logic [AW-1:0] bus_addr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (ld) begin
            held <= sw_addr;
        end else if (step) begin
            held <= held + ONE;
        end
    end

    assign bus_addr = oe_n ? {AW{1'bz}} : held;

endmodule

// File: rtl/panel_examine_ctrl.sv
module panel_examine_ctrl
    import pnl_pkg::*;
#(
    parameter int AW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_examine,
    input  logic          sw_exam_next,
    input  logic [AW-1:0] sw_addr,
    input  logic          cpu_owns_bus,
    output logic [AW-1:0] bus_addr,
    output logic          bus_oe_n,
    output logic          mem_rd,
    output logic          disp_latch,
    output logic          addr_load,
    output logic          addr_step
);

    logic [SW_COUNT-1:0] sw_raw;
    logic [SW_COUNT-1:0] sw_level;
    logic [SW_COUNT-1:0] sw_rise;
    logic [AW-1:0]       held_addr;

    assign sw_raw[SW_EXAM] = sw_examine;
    assign sw_raw[SW_NEXT] = sw_exam_next;

    pnl_sw_sync #(
        .N      (SW_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (sw_raw),
        .level (sw_level),
        .rise  (sw_rise)
    );

    pnl_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .exam_rise    (sw_rise[SW_EXAM]),
        .next_rise    (sw_rise[SW_NEXT]),
        .exam_level   (sw_level[SW_EXAM]),
        .next_level   (sw_level[SW_NEXT]),
        .cpu_owns_bus (cpu_owns_bus),
        .ld_pulse     (addr_load),
        .step_pulse   (addr_step),
        .oe_n         (bus_oe_n),
        .rd           (mem_rd),
        .latch        (disp_latch)
    );

    pnl_addr_hold #(
        .AW (AW)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (addr_load),
        .step     (addr_step),
        .oe_n     (bus_oe_n),
        .sw_addr  (sw_addr),
        .held     (held_addr),
        .bus_addr (bus_addr)
    );

endmodule

// File: rtl/pnl_checker.sv
module pnl_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] sw_addr,
    input logic          cpu_owns_bus,
    input logic          addr_load,
    input logic          addr_step,
    input logic          bus_oe_n,
    input logic          mem_rd,
    input logic          disp_latch,
    input logic [AW-1:0] held_addr
);

    p_load_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> !addr_load);

    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> (held_addr == $past(sw_addr)));

    p_step_plus_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_step |=> (held_addr == $past(held_addr) + AW'(1)));

    p_drive_after_action_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load || addr_step) ##1 !cpu_owns_bus |-> !bus_oe_n);

    p_latch_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_latch |-> (!bus_oe_n && mem_rd && $past(!bus_oe_n)));

    p_cpu_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_owns_bus |-> (bus_oe_n && !mem_rd && !disp_latch && !addr_load && !addr_step));

    p_held_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_owns_bus |=> $stable(held_addr));

endmodule

bind panel_examine_ctrl pnl_checker #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_addr      (sw_addr),
    .cpu_owns_bus (cpu_owns_bus),
    .addr_load    (addr_load),
    .addr_step    (addr_step),
    .bus_oe_n     (bus_oe_n),
    .mem_rd       (mem_rd),
    .disp_latch   (disp_latch),
    .held_addr    (held_addr)
);

// File: tb/panel_examine_ctrl_test.sv
module panel_examine_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_examine = 1'b0;
    logic          sw_exam_next = 1'b0;
    logic [AW-1:0] sw_addr = '0;
    logic          cpu_owns_bus = 1'b0;
    wire  [AW-1:0] bus_addr;
    logic          bus_oe_n;
    logic          mem_rd;
    logic          disp_latch;
    logic          addr_load;
    logic          addr_step;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_examine_ctrl #(.AW(AW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_examine   (sw_examine),
        .sw_exam_next (sw_exam_next),
        .sw_addr      (sw_addr),
        .cpu_owns_bus (cpu_owns_bus),
        .bus_addr     (bus_addr),
        .bus_oe_n     (bus_oe_n),
        .mem_rd       (mem_rd),
        .disp_latch   (disp_latch),
        .addr_load    (addr_load),
        .addr_step    (addr_step)
    );

    // ---------------- reference model ----------------
    // Sample histories: index 0 is the newest registered sample.
    int        ex_hist[$];
    int        nx_hist[$];
    int        phase;      // 0 idle, 1 action, 2 first read, 3 display
    bit        kind_load;
    int        m_addr;

    function automatic void model_clear();
        ex_hist = '{0, 0, 0};
        nx_hist = '{0, 0, 0};
        phase = 0;
        kind_load = 0;
        m_addr = 0;
    endfunction

    initial model_clear();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
        end else begin
            bit ex_edge;
            bit nx_edge;
            ex_edge = (ex_hist[1] != 0) && (ex_hist[2] == 0);
            nx_edge = (nx_hist[1] != 0) && (nx_hist[2] == 0);
            if (cpu_owns_bus) begin
                phase = 0;
            end else if (phase == 0) begin
                if (ex_edge && nx_hist[1] == 0) begin
                    phase = 1; kind_load = 1;
                end else if (nx_edge && ex_hist[1] == 0) begin
                    phase = 1; kind_load = 0;
                end
            end else if (phase == 1) begin
                if (kind_load) m_addr = int'(sw_addr);
                else           m_addr = (m_addr + 1) % (1 << AW);
                phase = 2;
            end else if (phase == 2) begin
                phase = 3;
            end else begin
                phase = 0;
            end
            void'(ex_hist.pop_back());
            void'(nx_hist.pop_back());
            ex_hist.push_front(int'(sw_examine));
            nx_hist.push_front(int'(sw_exam_next));
        end
    end

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic check_val(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit act_win;
            act_win = (phase == 2 || phase == 3) && !cpu_owns_bus;
            check_bit("R2", "addr_load", addr_load, phase == 1 && kind_load && !cpu_owns_bus);
            check_bit("R3", "addr_step", addr_step, phase == 1 && !kind_load && !cpu_owns_bus);
            check_bit("R5", "bus_oe_n", bus_oe_n, !act_win);
            check_bit("R6", "mem_rd", mem_rd, act_win);
            check_bit("R6", "disp_latch", disp_latch, phase == 3 && !cpu_owns_bus);
            if (act_win) check_val("R5", "bus_addr", bus_addr, AW'(m_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic press_exam(input logic [AW-1:0] a, input int hold);
        sw_addr = a;
        sw_examine = 1'b1;
        idle(hold);
        sw_examine = 1'b0;
    endtask

    task automatic press_next(input int hold);
        sw_exam_next = 1'b1;
        idle(hold);
        sw_exam_next = 1'b0;
    endtask

    // Wait for a display strobe and check the address shown.
    task automatic expect_show(input string tag, input logic [AW-1:0] exp);
        bit seen;
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (disp_latch === 1'b1) begin
                seen = 1;
                check_val(tag, "shown address", bus_addr, exp);
            end
        end
        if (!seen) check_bit(tag, "display strobe seen", 1'b0, 1'b1);
        #2;
    endtask

    // No bus drive and no strobe for n cycles.
    task automatic expect_quiet(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_bit(tag, "bus_oe_n stays high", bus_oe_n, 1'b1);
            check_bit(tag, "no register pulse", addr_load | addr_step, 1'b0);
        end
        #2;
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        idle(3);
        @(negedge clk);
        check_bit("R1", "reset bus_oe_n", bus_oe_n, 1'b1);
        check_bit("R1", "reset mem_rd", mem_rd, 1'b0);
        check_bit("R1", "reset disp_latch", disp_latch, 1'b0);
        check_bit("R1", "reset addr_load", addr_load, 1'b0);
        check_bit("R1", "reset addr_step", addr_step, 1'b0);
        #2;
        rst_n = 1'b1;
        idle(3);

        // R1: first step from reset shows address 1
        press_next(2);
        expect_show("R1", 16'h0001);
        idle(4);

        // R2: long press loads once (R9)
        press_exam(16'h1234, 12);
        expect_quiet("R9", 6);
        idle(2);
        press_exam(16'hA5C3, 1);
        expect_show("R2", 16'hA5C3);
        idle(4);

        // R3: several steps
        for (int k = 1; k <= 3; k++) begin
            press_next(3);
            expect_show("R3", 16'hA5C3 + 16'(k));
            idle(4);
        end

        // R4: wrap from all ones
        press_exam(16'hFFFF, 2);
        expect_show("R4", 16'hFFFF);
        idle(4);
        press_next(2);
        expect_show("R4", 16'h0000);
        idle(4);

        // R7: Examine while Examine Next is held
        sw_exam_next = 1'b1;
        idle(6);
        press_exam(16'h5555, 3);
        idle(1);
        sw_exam_next = 1'b0;
        expect_quiet("R7", 6);
        // R7: both rising together
        sw_addr = 16'h6666;
        sw_examine = 1'b1;
        sw_exam_next = 1'b1;
        idle(4);
        sw_examine = 1'b0;
        sw_exam_next = 1'b0;
        expect_quiet("R7", 6);
        press_next(2);
        expect_show("R7", 16'h0002);
        idle(4);

        // R9: second press inside a running sequence is ignored
        press_exam(16'h0100, 1);
        idle(2);
        press_next(1);
        expect_show("R9", 16'h0100);
        expect_quiet("R9", 6);

        // R8: presses under processor ownership are lost
        cpu_owns_bus = 1'b1;
        press_exam(16'h7777, 2);
        idle(2);
        press_next(2);
        expect_quiet("R8", 6);
        cpu_owns_bus = 1'b0;
        idle(2);
        press_next(2);
        expect_show("R8", 16'h0101);
        idle(4);

        // R8: sequence abandoned when the processor takes the bus
        press_exam(16'h2222, 1);
        idle(3);
        cpu_owns_bus = 1'b1;
        expect_quiet("R8", 4);
        cpu_owns_bus = 1'b0;
        idle(4);
        press_next(2);
        expect_show("R8", 16'h2223);
        idle(6);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule